// File: doc/BRIEF.md
# Shared-Interrupt Affinity Routing Table

This block keeps a 64-bit routing entry for every implemented shared interrupt and turns the entry of a pending interrupt into a processing-element (PE) target. Software reaches the entries through a 32-bit memory-mapped register port. Each entry takes two words. The port decodes the address and clears the reserved bits. It makes an access read as zero and drops its write when routing is off, when the index is not implemented, or when a non-secure requester may not touch that interrupt.

A separate resolve port takes an interrupt ID and returns a result one cycle later. The result is either a one-hot PE target or "no target". The choice uses a table of PE affinity addresses with two per-PE masks: one marks a PE as present, the other marks it as a member of the any-PE pool. An entry either names one PE by a four-level affinity address, or asks for any pool member. Pool members are served in rotating order.

The upper word of an entry only reaches the routing state when the lower word is written. A resolve therefore always sees one complete entry, either the old one or the new one.

Top module: `rtb_route_bank`

## Requirements
- R1: Entry of interrupt ID k (32 <= k < 32+32*LINE_GROUPS) is the word at byte address 0x6000+8*k (lower) and 0x6000+8*k+4 (upper). A read returns data on `cfg_rdata` in the cycle after `cfg_rd` and returns zero in any cycle without a read. A written value reads back.
- R2: Lower word reads place the mode bit at 31, affinity level 2 at 23:16, level 1 at 15:8 and level 0 at 7:0, with bits 30:24 always zero. Upper word reads place level 3 at 7:0, with bits 31:8 always zero.
- R3: Any access outside 0x6000..0x7FFF, or to an ID below 32 or beyond the last implemented ID, reads zero and its write changes nothing. A resolve of such an ID gives no target.
- R4: While `aff_route_en` is 0, all entries read zero and writes are dropped.
- R5: While `sec_disable` is 0, a `cfg_ns` access to an interrupt with `irq_secure` set and `irq_ns_ok` clear reads zero and is dropped. Secure accesses, or accesses with `irq_ns_ok` set, proceed.
- R6: An upper-word write is staged. Upper-word reads return the staged value at once, but routing keeps the previous level-3 value until the next lower-word write of that entry commits both words together.
- R7: With mode 0, the result one cycle after `rs_req` targets the lowest-numbered present PE whose 32-bit affinity {L3,L2,L1,L0} equals the entry. No match gives `rs_hit`=0 and a zero target. `rs_valid` follows `rs_req` by one cycle.
- R8: With mode 1, the target is the first PE that is both present and a pool member, searching from a rotating pointer. After each such delivery the pointer moves just past the chosen PE. An empty pool gives no target and leaves the pointer unchanged.
- R9: While `dist_any_off` is 1, a mode bit of 1 routes as mode 0, and the lower word still reads back with bit 31 set.
- R10: While `aff_route_en` is 0, every resolve gives no target.
- R11: After reset every entry reads zero, the rotating pointer is at PE 0, and the resolve outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aff_route_en | input | 1 | Affinity routing enabled |
| sec_disable | input | 1 | Security filtering off when 1 |
| dist_any_off | input | 1 | Any-PE distribution unsupported |
| irq_secure | input | NENT | Per entry: interrupt is Group 0 or Secure Group 1 (bit i = ID 32+i) |
| irq_ns_ok | input | NENT | Per entry: non-secure access granted |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_ns | input | 1 | Access is non-secure |
| cfg_addr | input | 16 | Byte address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after read |
| rs_req | input | 1 | Resolve request |
| rs_id | input | 10 | Interrupt ID to resolve |
| rs_valid | output | 1 | Resolve result valid |
| rs_hit | output | 1 | A target was found |
| rs_target | output | NUM_PE | One-hot target PE |
| pe_affinity | input | 32*NUM_PE | Per-PE affinity {L3,L2,L1,L0} |
| pe_present | input | NUM_PE | PE implemented |
| pe_member | input | NUM_PE | PE takes part in any-PE distribution |

## Verification
Direct routing is tried with affinities that match a single PE, and with affinities that differ from a PE only in level 3 or only in level 0. These patterns show whether all four levels take part in the match. They also show whether a staged level-3 value stays out of routing until the lower word commits. Any-PE routing is tried with a pool that has a gap and with an empty pool, and direct resolves are mixed in between. This tells correct rotation and pointer hold apart from a pointer that moves on every request. Register access is tried with every cause of read-as-zero: routing off, a reserved index, an index past the end, outside the window, and a blocked non-secure access. Each cause is followed by a permitted read, which shows that a dropped write left the stored value untouched.

// File: rtl/rtb_pkg.sv
// Shared types and constants for the affinity routing table.
// Assumes interrupt IDs below FIRST_ID are never routed by this block.
package rtb_pkg;

    localparam int FIRST_ID = 32;
    localparam int MAX_ENT  = 988;   // IDs 32..1019

    // Stored routing state of one entry (reserved bits are not kept).
    typedef struct packed {
        logic       any_pe;
        logic [7:0] l3;
        logic [7:0] l2;
        logic [7:0] l1;
        logic [7:0] l0;
    } rtb_entry_t;

    // Number of entries for a given count of 32-interrupt groups.
    function automatic int ent_count(input int groups);
        int v;
        v = 32 * groups;
        if (v > MAX_ENT) v = MAX_ENT;
        return v;
    endfunction

endpackage

// File: rtl/rtb_regfile.sv
// Register storage and 32-bit access port for the routing entries.
// Decodes the 0x6000 window, applies read-as-zero / write-ignored rules,
// stages level-3 affinity until the lower word commits, and offers one
// combinational lookup port for the resolver. Assumes word-aligned access.
module rtb_regfile
    import rtb_pkg::*;
#(
    parameter  int NENT = 32,
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aff_route_en,
    input  logic             sec_disable,
    input  logic [NENT-1:0]  irq_secure,
    input  logic [NENT-1:0]  irq_ns_ok,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic             cfg_ns,
    input  logic [15:0]      cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [IW-1:0]    lk_idx,
    output rtb_entry_t       lk_entry
);

    localparam logic [10:0] ID_END = 11'(FIRST_ID + NENT);

    rtb_entry_t  live_q  [NENT];
    logic [7:0]  stage_q [NENT];

    logic [9:0]    acc_id;
    logic          in_win;
    logic          id_impl;
    logic [IW-1:0] loc;
    logic          ns_block;
    logic          acc_ok;
    logic          unused_bits;

    // Address decode and access permission for the current request.
    always_comb begin
        acc_id   = cfg_addr[12:3];
        in_win   = (cfg_addr[15:13] == 3'b011);
        id_impl  = in_win && (acc_id >= 10'd32) && ({1'b0, acc_id} < ID_END);
        loc      = IW'(acc_id - 10'd32);
        ns_block = !sec_disable && cfg_ns && irq_secure[loc] && !irq_ns_ok[loc];
        acc_ok   = aff_route_en && id_impl && !ns_block;
    end

    assign unused_bits = ^{cfg_wdata[30:24], cfg_addr[1:0]};

    // Entry and staging storage: upper writes stage, lower writes commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                live_q[i]  <= '0;
                stage_q[i] <= '0;
            end
        end else if (cfg_wr && acc_ok) begin
            if (cfg_addr[2]) begin
                stage_q[loc] <= cfg_wdata[7:0];
            end else begin
                live_q[loc] <= '{any_pe: cfg_wdata[31], l3: stage_q[loc],
                                 l2: cfg_wdata[23:16], l1: cfg_wdata[15:8],
                                 l0: cfg_wdata[7:0]};
            end
        end
    end

    // Registered read data with reserved fields forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_rd && acc_ok) begin
            if (cfg_addr[2]) cfg_rdata <= {24'd0, stage_q[loc]};
            else cfg_rdata <= {live_q[loc].any_pe, 7'd0, live_q[loc].l2,
                               live_q[loc].l1, live_q[loc].l0};
        end else begin
            cfg_rdata <= '0;
        end
    end

    assign lk_entry = live_q[lk_idx];

    // Arms the history-based checks one cycle after reset.
    logic chk_armed;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && !$past(cfg_rd)) |-> (cfg_rdata == 32'd0));
    assert_rsvd_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(cfg_rd && !cfg_addr[2])) |-> (cfg_rdata[30:24] == 7'd0));
    assert_rsvd_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(cfg_rd && cfg_addr[2])) |-> (cfg_rdata[31:8] == 24'd0));
    assert_low_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(cfg_rd && cfg_addr[15:13] != 3'b011)) |-> (cfg_rdata == 32'd0));
    assert_off_raz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(cfg_rd && !aff_route_en)) |-> (cfg_rdata == 32'd0));

endmodule

// File: rtl/rtb_resolve.sv
// Turns the committed entry of a requested interrupt into a one-hot PE
// target: exact four-level affinity match, or rotating choice among pool
// members. Result is registered one cycle after the request. Assumes the
// entry lookup from the register file is combinational.
module rtb_resolve
    import rtb_pkg::*;
#(
    parameter  int NENT   = 32,
    parameter  int NUM_PE = 4,
    localparam int IW     = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int PW     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  aff_route_en,
    input  logic                  dist_any_off,
    input  logic                  rs_req,
    input  logic [9:0]            rs_id,
    output logic [IW-1:0]         lk_idx,
    input  rtb_entry_t            lk_entry,
    input  logic [32*NUM_PE-1:0]  pe_affinity,
    input  logic [NUM_PE-1:0]     pe_present,
    input  logic [NUM_PE-1:0]     pe_member,
    output logic                  rs_valid,
    output logic                  rs_hit,
    output logic [NUM_PE-1:0]     rs_target
);

    localparam logic [10:0] ID_END = 11'(FIRST_ID + NENT);

    logic              id_ok;
    logic              use_any;
    logic [NUM_PE-1:0] dsel;
    logic [NUM_PE-1:0] rsel;
    logic [NUM_PE-1:0] sel;
    logic [NUM_PE-1:0] elig;
    logic [PW-1:0]     ptr_q;
    logic [PW-1:0]     ptr_nx;
    logic              hit;

    // ID range check and entry lookup index.
    always_comb begin
        id_ok   = (rs_id >= 10'd32) && ({1'b0, rs_id} < ID_END);
        lk_idx  = IW'(rs_id - 10'd32);
        use_any = lk_entry.any_pe && !dist_any_off;
        elig    = pe_present & pe_member;
    end

    // Direct match: lowest-numbered present PE with equal affinity.
    always_comb begin
        dsel = '0;
        for (int i = NUM_PE - 1; i >= 0; i--) begin
            if (pe_present[i] && (pe_affinity[i*32 +: 32] ==
                {lk_entry.l3, lk_entry.l2, lk_entry.l1, lk_entry.l0})) begin
                dsel    = '0;
                dsel[i] = 1'b1;
            end
        end
    end

    // Rotating search over eligible PEs starting at the pointer.
    always_comb begin
        logic found;
        found  = 1'b0;
        rsel   = '0;
        ptr_nx = ptr_q;
        for (int k = 0; k < NUM_PE; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= NUM_PE) j = j - NUM_PE;
            if (!found && elig[j]) begin
                found   = 1'b1;
                rsel[j] = 1'b1;
                ptr_nx  = (j == NUM_PE - 1) ? '0 : PW'(j + 1);
            end
        end
    end

    assign sel = use_any ? rsel : dsel;
    assign hit = aff_route_en && id_ok && (|sel);

    // Result registers and rotating pointer advance on any-PE delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid  <= 1'b0;
            rs_hit    <= 1'b0;
            rs_target <= '0;
            ptr_q     <= '0;
        end else begin
            rs_valid  <= rs_req;
            rs_hit    <= rs_req && hit;
            rs_target <= (rs_req && hit) ? sel : '0;
            if (rs_req && hit && use_any) ptr_q <= ptr_nx;
        end
    end

    // Arms the history-based checks one cycle after reset.
    logic chk_armed;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    assert_tgt_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rs_target));
    assert_hit_tgt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit == (rs_target != '0));
    assert_valid_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_armed |-> (rs_valid == $past(rs_req)));
    assert_tgt_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && rs_hit) |-> ((rs_target & ~$past(pe_present)) == '0));
    assert_pool_member_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && rs_hit && $past(use_any)) |-> ((rs_target & ~$past(pe_member)) == '0));
    assert_off_notgt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(rs_req && !aff_route_en)) |-> !rs_hit);
    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < NUM_PE);

endmodule

// File: rtl/rtb_route_bank.sv
// Top of the affinity routing table: register file plus target resolver.
// Assumes the PE affinity table and masks are stable while resolving.
module rtb_route_bank
    import rtb_pkg::*;
#(
    parameter  int LINE_GROUPS = 1,
    parameter  int NUM_PE      = 4,
    localparam int NENT        = ent_count(LINE_GROUPS),
    localparam int IW          = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  aff_route_en,
    input  logic                  sec_disable,
    input  logic                  dist_any_off,
    input  logic [NENT-1:0]       irq_secure,
    input  logic [NENT-1:0]       irq_ns_ok,
    input  logic                  cfg_wr,
    input  logic                  cfg_rd,
    input  logic                  cfg_ns,
    input  logic [15:0]           cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  rs_req,
    input  logic [9:0]            rs_id,
    output logic                  rs_valid,
    output logic                  rs_hit,
    output logic [NUM_PE-1:0]     rs_target,
    input  logic [32*NUM_PE-1:0]  pe_affinity,
    input  logic [NUM_PE-1:0]     pe_present,
    input  logic [NUM_PE-1:0]     pe_member
);

    logic [IW-1:0] lk_idx;
    rtb_entry_t    lk_entry;

    rtb_regfile #(.NENT(NENT)) u_regs (
        .clk(clk), .rst_n(rst_n), .aff_route_en(aff_route_en),
        .sec_disable(sec_disable), .irq_secure(irq_secure), .irq_ns_ok(irq_ns_ok),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_ns(cfg_ns), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_idx(lk_idx), .lk_entry(lk_entry)
    );

    rtb_resolve #(.NENT(NENT), .NUM_PE(NUM_PE)) u_res (
        .clk(clk), .rst_n(rst_n), .aff_route_en(aff_route_en),
        .dist_any_off(dist_any_off), .rs_req(rs_req), .rs_id(rs_id),
        .lk_idx(lk_idx), .lk_entry(lk_entry), .pe_affinity(pe_affinity),
        .pe_present(pe_present), .pe_member(pe_member),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_target(rs_target)
    );

endmodule

// File: tb/sim_rtb_route_bank.sv
`timescale 1ns/1ps
module sim_rtb_route_bank;

    localparam int NP = 4;
    localparam int NE = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aff_route_en = 1'b0, sec_disable = 1'b1, dist_any_off = 1'b0;
    logic [NE-1:0] irq_secure = '0, irq_ns_ok = '0;
    logic cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_ns = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic rs_req = 1'b0;
    logic [9:0] rs_id = '0;
    logic rs_valid, rs_hit;
    logic [NP-1:0] rs_target;
    logic [32*NP-1:0] pe_affinity;
    logic [NP-1:0] pe_present = 4'b1111, pe_member = 4'b1011;

    assign pe_affinity = {32'h00102133, 32'h00102032, 32'h01102030, 32'h00102030};

    rtb_route_bank #(.LINE_GROUPS(1), .NUM_PE(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .aff_route_en(aff_route_en),
        .sec_disable(sec_disable), .dist_any_off(dist_any_off),
        .irq_secure(irq_secure), .irq_ns_ok(irq_ns_ok),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_ns(cfg_ns), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rs_req(rs_req), .rs_id(rs_id), .rs_valid(rs_valid), .rs_hit(rs_hit),
        .rs_target(rs_target), .pe_affinity(pe_affinity),
        .pe_present(pe_present), .pe_member(pe_member)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    string cur_req = "R11";
    bit done = 1'b0;

    // Behavioural reference model.
    bit          m_any [NE];
    logic [31:0] m_aff [NE];
    logic [7:0]  m_stg [NE];
    int          m_ptr;
    logic [31:0] e_rdata;
    logic        e_valid, e_hit;
    logic [NP-1:0] e_tgt;

    function automatic bit id_in(input int id);
        return id >= 32 && id < 32 + NE;
    endfunction

    function automatic bit acc_ok(input logic [15:0] a);
        int id;
        id = int'(a[12:3]);
        if (a[15:13] != 3'b011 || !id_in(id) || !aff_route_en) return 0;
        if (!sec_disable && cfg_ns && irq_secure[id-32] && !irq_ns_ok[id-32]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin
                m_any[i] = 0; m_aff[i] = 0; m_stg[i] = 0;
            end
            m_ptr = 0; e_rdata = 0; e_valid = 0; e_hit = 0; e_tgt = 0;
        end else begin
            int n;
            e_rdata = 0;
            if (cfg_rd && acc_ok(cfg_addr)) begin
                n = int'(cfg_addr[12:3]) - 32;
                if (cfg_addr[2]) e_rdata = {24'd0, m_stg[n]};
                else e_rdata = {m_any[n], 7'd0, m_aff[n][23:0]};
            end
            e_valid = rs_req; e_hit = 0; e_tgt = 0;
            if (rs_req && aff_route_en && id_in(int'(rs_id))) begin
                n = int'(rs_id) - 32;
                if (m_any[n] && !dist_any_off) begin
                    for (int k = 0; k < NP; k++) begin
                        int j;
                        j = (m_ptr + k) % NP;
                        if (!e_hit && pe_present[j] && pe_member[j]) begin
                            e_hit = 1; e_tgt[j] = 1'b1; m_ptr = (j + 1) % NP;
                        end
                    end
                end else begin
                    for (int i = 0; i < NP; i++)
                        if (!e_hit && pe_present[i] && pe_affinity[i*32 +: 32] == m_aff[n]) begin
                            e_hit = 1; e_tgt[i] = 1'b1;
                        end
                end
            end
            if (cfg_wr && acc_ok(cfg_addr)) begin
                n = int'(cfg_addr[12:3]) - 32;
                if (cfg_addr[2]) m_stg[n] = cfg_wdata[7:0];
                else begin
                    m_any[n] = cfg_wdata[31];
                    m_aff[n] = {m_stg[n], cfg_wdata[23:0]};
                end
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (cfg_rdata !== e_rdata) begin
                failures++;
                $display("FAIL %s rdata act=%h exp=%h", cur_req, cfg_rdata, e_rdata);
            end
            checks++;
            if (rs_valid !== e_valid || rs_hit !== e_hit || rs_target !== e_tgt) begin
                failures++;
                $display("FAIL %s resolve act=%b/%b/%b exp=%b/%b/%b", cur_req,
                         rs_valid, rs_hit, rs_target, e_valid, e_hit, e_tgt);
            end
        end
    end

    function automatic logic [15:0] ea(input int id, input bit hi);
        return 16'(16'h6000 + id * 8 + (hi ? 4 : 0));
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit ns = 0);
        @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cfg_ns = ns;
        @(negedge clk); cfg_wr = 0; cfg_ns = 0;
    endtask

    task automatic rd(input logic [15:0] a, input bit ns = 0);
        @(negedge clk); cfg_rd = 1; cfg_addr = a; cfg_ns = ns;
        @(negedge clk); cfg_rd = 0; cfg_ns = 0;
    endtask

    task automatic rs(input int id);
        @(negedge clk); rs_req = 1; rs_id = 10'(id);
        @(negedge clk); rs_req = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R11";
        rd(ea(32, 0)); rd(ea(32, 1)); rs(32);
        aff_route_en = 1;
        rd(ea(40, 0)); rs(40);

        cur_req = "R1";
        wr(ea(40, 0), 32'h0010_2030); rd(ea(40, 0));
        wr(ea(40, 1), 32'h0000_0001); rd(ea(40, 1));

        cur_req = "R2";
        wr(ea(41, 0), 32'hFFFF_FFFF); rd(ea(41, 0));
        wr(ea(41, 1), 32'hFFFF_FFFF); rd(ea(41, 1));

        cur_req = "R6";
        rs(40);                              // level 3 still 0 -> PE0
        wr(ea(40, 0), 32'h0010_2030); rs(40); // committed level 3 = 1 -> PE1

        cur_req = "R7";
        wr(ea(42, 0), 32'h0010_2032); rs(42);
        wr(ea(43, 0), 32'h0010_2133); rs(43);
        wr(ea(44, 0), 32'h0010_2099); rs(44);

        cur_req = "R8";
        wr(ea(45, 0), 32'h8000_0000);
        rs(45); rs(45); rs(42); rs(45); rs(45); rs(45);
        pe_member = 4'b0000; rs(45);
        pe_member = 4'b0100; rs(45); rs(45);
        pe_member = 4'b1011;

        cur_req = "R9";
        dist_any_off = 1; rs(45); rd(ea(45, 0));
        dist_any_off = 0;

        cur_req = "R3";
        wr(ea(31, 0), 32'h0010_2030); rd(ea(31, 0)); rs(31);
        wr(ea(64, 0), 32'h0010_2030); rd(ea(64, 0)); rs(64); rs(1019);
        wr(16'h5008, 32'h1234_5678); rd(16'h5008); rd(ea(33, 0));

        cur_req = "R4";
        aff_route_en = 0;
        rd(ea(40, 0)); wr(ea(40, 0), 32'h0); wr(ea(40, 1), 32'h0);
        cur_req = "R10";
        rs(40);
        aff_route_en = 1;
        cur_req = "R4";
        rd(ea(40, 0)); rd(ea(40, 1)); rs(40);

        cur_req = "R5";
        sec_disable = 0; irq_secure[8] = 1;
        rd(ea(40, 0), 1); wr(ea(40, 0), 32'h0, 1); rd(ea(40, 0), 0);
        irq_ns_ok[8] = 1;
        rd(ea(40, 0), 1); wr(ea(40, 0), 32'h0010_2032, 1); rd(ea(40, 0), 0); rs(40);
        sec_disable = 1;

        repeat (3) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule